// File: doc/BRIEF.md
# Presettable Cascadable Up/Down Counter

A four-bit synchronous counter that can step in either direction. A parameter selects its modulus. In binary mode it cycles through sixteen states. In decade mode it cycles through the ten digits 0 to 9. All state bits change together on a rising clock edge, and only while the active-low enable is low. An active-low load input copies the data bus into the counter at once, whatever the level of the clock.

Two outputs support chaining:

- **Terminal flag.** It is high while the counter sits on the last value of its current direction. Downstream logic can use it as a look-ahead enable.
- **Active-low ripple output.** It repeats that condition, but only during the low phase of the clock and only while counting is enabled. It can feed the enable of a following stage on a shared clock, or that stage's clock on a shared enable.

The control pins are plain levels. There is no data stream here and no back-pressure.

Top module: `updown_cascade_counter`

## Requirements
- R1: On a rising clock edge with load_n high, the count changes only when en_n is low. With en_n high the count holds.
- R2: With dn low, each enabled edge adds one to the count. With dn high, each enabled edge subtracts one.
- R3: While load_n is low, q equals d with no clock edge needed, and counting is overridden. After load_n returns high, counting resumes from that value. d must stay stable while load_n is low.
- R4: With DECADE=0, counting up from 15 gives 0 and counting down from 0 gives 15.
- R5: With DECADE=1, counting up from 9 gives 0 and counting down from 0 gives 9. From a preset value of 10 to 15, the next enabled edge gives 0 when counting up and 9 when counting down.
- R6: term is high exactly when dn is low and q is the last value (15 binary, 9 decade), or when dn is high and q is 0. The level of en_n does not affect it.
- R7: rco_n is low exactly while term is high, en_n is low and clk is low. It is high at every other time.
- R8: Two decade stages on a common clock form a two-digit counter when the upper stage's enable is the lower stage's enable ORed with the inverted lower term. The pair steps 00..99 upward and 99..00 downward, and wraps at both ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counting happens on the rising edge |
| en_n | input | 1 | Active-low count enable |
| dn | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Active-low asynchronous parallel load |
| d | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| term | output | 1 | Max/min terminal-count flag |
| rco_n | output | 1 | Active-low ripple output, gated by the clock low phase |

## Verification
The undefined decade states 10 to 15 never occur through counting. The bench reaches each of them only by holding load across an edge, then releases load and takes one enabled step in each direction.

The ripple output exists only during the low half of the clock. The bench therefore samples it in the middle of every low phase, and checks that it is high in every high phase.

The carry between stages only matters at the digit boundaries. Full up and down runs over all hundred states of a two-stage decade chain exercise every boundary, including both wraps.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;
  function automatic int unsigned last_of(input bit decade, input int unsigned width);
    return decade ? 9 : (1 << width) - 1;
  endfunction
endpackage

// File: rtl/cnt_step.sv
`timescale 1ns/1ps
module cnt_step #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             dn,
  output logic [WIDTH-1:0] nxt
);
  localparam int unsigned LAST = cnt_pkg::last_of(DECADE, WIDTH);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

  generate
    if (DECADE) begin : g_dec
      always_comb begin
        if (!dn) nxt = (cur >= LAST_V) ? '0 : WIDTH'(cur + 1'b1);
        else     nxt = (cur == '0 || cur > LAST_V) ? LAST_V : WIDTH'(cur - 1'b1);
      end
    end else begin : g_bin
      always_comb begin
        if (!dn) nxt = WIDTH'(cur + 1'b1);
        else     nxt = WIDTH'(cur - 1'b1);
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_term.sv
`timescale 1ns/1ps
module cnt_term #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             dn,
  output logic             term
);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(cnt_pkg::last_of(DECADE, WIDTH));
  logic at_top, at_bottom;
  assign at_top    = (cur == LAST_V);
  assign at_bottom = (cur == '0);
  assign term      = dn ? at_bottom : at_top;
endmodule

// File: rtl/cnt_ripple.sv
`timescale 1ns/1ps
module cnt_ripple (
  input  logic clk,
  input  logic en_n,
  input  logic term,
  output logic rco_n
);
  // low only in the low clock phase of an enabled terminal cycle
  assign rco_n = ~(term & ~en_n & ~clk);
endmodule

// File: rtl/updown_cascade_counter.sv
`timescale 1ns/1ps
module updown_cascade_counter #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic             clk,
  input  logic             en_n,
  input  logic             dn,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             term,
  output logic             rco_n
);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(cnt_pkg::last_of(DECADE, WIDTH));

  logic [WIDTH-1:0] st, nxt;

  cnt_step #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
    .cur(st), .dn(dn), .nxt(nxt)
  );

  // asynchronous preset has priority over counting
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)     st <= d;
    else if (!en_n)  st <= nxt;
  end

  assign q = load_n ? st : d;

  cnt_term #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
    .cur(q), .dn(dn), .term(term)
  );

  cnt_ripple u_rip (
    .clk(clk), .en_n(en_n), .term(term), .rco_n(rco_n)
  );

  // R1: a disabled edge keeps the count
  a_r1_hold: assert property (@(posedge clk) disable iff (!load_n)
    ($past(en_n) && $past(load_n)) |-> (st == $past(st)));

  // R2: enabled up step below the last value adds one
  a_r2_up_step: assert property (@(posedge clk) disable iff (!load_n)
    ($past(!en_n) && $past(!dn) && $past(load_n) && ($past(st) < LAST_V))
    |-> (st == WIDTH'($past(st) + 1'b1)));

  // R4/R5: leaving a terminal state lands on the opposite end
  a_r4_wrap: assert property (@(posedge clk) disable iff (!load_n)
    ($past(term) && $past(!en_n) && $past(load_n))
    |-> (st == ($past(dn) ? LAST_V : '0)));

  // R5: any enabled step in decade mode gives a legal digit
  a_r5_bcd_legal: assert property (@(posedge clk) disable iff (!load_n)
    (DECADE && $past(!en_n) && $past(load_n)) |-> (st <= LAST_V));

  // R7: ripple output is idle while the clock is high
  always_comb begin
    if (clk) a_r7_rco_high_phase: assert (rco_n);
  end
endmodule

// File: tb/sim_updown_cascade_counter.sv
`timescale 1ns/1ps
module sim_updown_cascade_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic en_n = 1'b1, dn = 1'b0, load_n = 1'b0;
  logic [3:0] d0 = '0, d1 = '0, d2 = '0;
  logic [3:0] q0, q1, q2;
  logic t0, t1, t2, r0, r1, r2;
  logic en2_n;

  int m0, m1, m2;
  int n_chk = 0, n_fail = 0;

  updown_cascade_counter #(.WIDTH(4), .DECADE(1'b0)) u0 (
    .clk(clk), .en_n(en_n), .dn(dn), .load_n(load_n), .d(d0),
    .q(q0), .term(t0), .rco_n(r0));
  updown_cascade_counter #(.WIDTH(4), .DECADE(1'b1)) u1 (
    .clk(clk), .en_n(en_n), .dn(dn), .load_n(load_n), .d(d1),
    .q(q1), .term(t1), .rco_n(r1));
  assign en2_n = en_n | ~t1;
  updown_cascade_counter #(.WIDTH(4), .DECADE(1'b1)) u2 (
    .clk(clk), .en_n(en2_n), .dn(dn), .load_n(load_n), .d(d2),
    .q(q2), .term(t2), .rco_n(r2));

  function automatic int step_of(input int m, input bit dec, input bit down);
    int md = dec ? 10 : 16;
    if (!down) return (m >= md - 1) ? 0 : m + 1;
    return (m == 0 || m >= md) ? md - 1 : m - 1;
  endfunction

  function automatic bit term_of(input int m, input bit dec, input bit down);
    return down ? (m == 0) : (m == (dec ? 9 : 15));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk("R1/R2 q0", q0, m0);
    chk("R1/R5 q1", q1, m1);
    chk("R8 q2", q2, m2);
    chk("R6 term0", t0, term_of(m0, 0, dn));
    chk("R6 term1", t1, term_of(m1, 1, dn));
  endtask

  // one clock: model update from inputs, check after the edge and in low phase
  task automatic tick();
    bit c1;
    if (!load_n) begin
      m0 = d0; m1 = d1; m2 = d2;
    end else if (!en_n) begin
      c1 = term_of(m1, 1, dn);
      m0 = step_of(m0, 0, dn);
      m1 = step_of(m1, 1, dn);
      if (c1) m2 = step_of(m2, 1, dn);
    end
    @(posedge clk); #1;
    check_outputs();
    chk("R7 rco0 high phase", r0, 1);
    chk("R7 rco1 high phase", r1, 1);
    @(negedge clk); #1;
    chk("R7 rco0 low phase", r0, !(term_of(m0, 0, dn) && !en_n));
    chk("R7 rco1 low phase", r1, !(term_of(m1, 1, dn) && !en_n));
  endtask

  task automatic preset(input int v0, input int v1, input int v2);
    load_n = 1'b0; d0 = 4'(v0); d1 = 4'(v1); d2 = 4'(v2);
    #0.5;
    chk("R3 async q0", q0, v0);
    chk("R3 async q1", q1, v1);
    chk("R3 async q2", q2, v2);
    tick();
    load_n = 1'b1;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m0 = 0; m1 = 0; m2 = 0;
    tick();                      // load active from time zero: all zero
    chk("R3 reset-state q0", q0, 0);
    chk("R3 reset-state q1", q1, 0);
    load_n = 1'b1;

    // R2/R4/R6: every binary value, both directions
    for (int v = 0; v < 16; v++) begin
      for (int dir = 0; dir < 2; dir++) begin
        dn = dir[0]; en_n = 1'b1;
        preset(v, v % 10, 0);
        en_n = 1'b0;
        tick();
      end
    end

    // R1: hold with enable high
    en_n = 1'b1; dn = 1'b0;
    preset(7, 4, 3);
    for (int i = 0; i < 4; i++) tick();

    // R5: illegal decade presets step to 0 (up) or 9 (down)
    for (int v = 10; v < 16; v++) begin
      for (int dir = 0; dir < 2; dir++) begin
        dn = dir[0]; en_n = 1'b1;
        preset(v, v, 0);
        en_n = 1'b0;
        tick();
        chk("R5 illegal recovers", q1, dir ? 9 : 0);
      end
    end

    // R8: two-digit chain up across 00..99 and wrap, then down
    en_n = 1'b1; dn = 1'b0;
    preset(0, 0, 0);
    en_n = 1'b0;
    for (int i = 0; i < 102; i++) tick();
    dn = 1'b1;
    for (int i = 0; i < 103; i++) tick();

    // R3: load during enabled counting overrides the edge
    dn = 1'b0;
    preset(12, 5, 8);
    for (int i = 0; i < 3; i++) tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule